// File: doc/BRIEF.md
# Message-signalled interrupt capability with per-vector masking

This block holds the register set of a PCI message-signalled interrupt capability. It also turns a vector of device interrupt levels into memory-write requests. Configuration software reaches the capability through a byte-wide port. Addresses on that port are offsets from the capability base. Writes take effect on the clock edge. Reads are combinational from the current register state. Software uses the port to program the target address, the data word, the enable bit, the number of enabled vectors and a per-vector mask.

Every cycle the block samples the device interrupt levels. A vector's rising edge is acted on when the vector is enabled and within the enabled count. If the vector is unmasked, the rising edge queues a message. If the vector is masked, the rising edge sets that vector's pending bit instead. A pending vector is queued as soon as its mask bit reads clear. Queued vectors leave one at a time on a valid/ready output, lowest vector number first. Back-pressure is simple. While `msg_valid` is high and `msg_ready` is low, the request holds its address and data unchanged. A new request may load on the same edge that accepts the previous one.

Parameters choose the vector count (1 to 32), the 32-bit or 64-bit address layout and the next-capability pointer.

Top module: `msi_cap`

## Requirements
- R1: Offset 0x00 reads the capability ID 0x05. Offset 0x01 reads the NEXT_PTR parameter. Writes to either offset have no effect.
- R2: A write to control offset 0x02 keeps bits 1, 2, 3 and 7 at their old values; only the other bits take the written value. Bit 0 is the enable. Bits 6:4 hold the enabled-count exponent. Bits 3:1 read the smallest exponent e with 2^e >= NUM_VEC. Bit 7 reads 1 in the 64-bit layout. Bits 0 and 6:4 reset to 0.
- R3: Offset 0x03 always reads 0x01, which advertises per-vector masking. Writes to it are ignored.
- R4: Multi-byte registers are little-endian, and the address low word is at 0x04. In the 64-bit layout, address high is at 0x08, data at 0x0C, mask at 0x10 and pending at 0x14. In the 32-bit layout, data is at 0x08, mask at 0x0C and pending at 0x10. Mask bits at or above NUM_VEC read 0. Unused offsets read 0.
- R5: With the enable bit set, a rising edge on an enabled, unmasked vector yields exactly one request. `msg_valid` goes high on the edge after the rising level is first presented. A level that stays high, or a falling level, yields nothing.
- R6: A rising edge on an enabled vector whose mask bit is 1 yields no request and sets that vector's pending bit. Software writes to the pending register have no effect.
- R7: When a vector's pending bit is 1 and its mask bit becomes 0, the request for that vector is queued on that same edge and the pending bit clears.
- R8: While the enable bit is 0, no new request starts and no pending bit is set. A rising edge that occurs while the enable bit is 0 is not acted on later.
- R9: Only vectors below 2^exponent are live; edges on other vectors are ignored. The request data is the data register with its low `exponent` bits replaced by the vector number. The request address is {address high, address low}, with the high word 0 in the 32-bit layout.
- R10: When several vectors are queued, the lowest-numbered one is sent first and the rest wait.
- R11: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid`, `msg_addr` and `msg_data` stay stable. The next queued request can load on the edge that accepts the current one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 8 | Byte offset from the capability base |
| cfg_we | input | 1 | Byte write strobe |
| cfg_wdata | input | 8 | Byte write data |
| cfg_rdata | output | 8 | Byte read data at cfg_addr (combinational) |
| irq_lvl | input | NUM_VEC | Device interrupt levels, one per vector |
| msg_valid | output | 1 | Memory-write request valid |
| msg_ready | input | 1 | Memory-write request accepted |
| msg_addr | output | 64 | Request address |
| msg_data | output | 32 | Request data |

## Verification
The bound assertions check the cycle-level rules on every cycle. A stalled request must hold its address and data. No request may start, and no pending bit may appear, while the enable bit is clear. A new pending bit may only appear on a vector that was masked. The bench's scenarios are needed for the rest: the exact message data for each vector and enabled count, lowest-first ordering, and release on unmask. They also cover the bit-level write filtering on the control byte and the register layout in both address modes.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam logic [7:0] CAP_ID_MSG_IRQ = 8'h05;
  localparam int OFS_CTL     = 2;
  localparam int OFS_ADDR_LO = 4;
  localparam int OFS_ADDR_HI = 8;
  // control low byte bits that ignore writes: 1,2,3 (capability count) and 7 (layout)
  localparam logic [7:0] CTL_RO_BITS = 8'h8E;

  typedef struct packed {
    logic       en;
    logic [2:0] exp_en;
  } irq_ctl_t;

  function automatic int data_ofs(input bit wide);
    return wide ? 12 : 8;
  endfunction
endpackage

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
  import msi_cap_pkg::*;
#(
  parameter int         NUM_VEC  = 4,
  parameter bit         ADDR64   = 1'b1,
  parameter logic [7:0] NEXT_PTR = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         cfg_addr,
  input  logic               cfg_we,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  input  logic [NUM_VEC-1:0] pend,
  output irq_ctl_t           ctl,
  output logic [31:0]        addr_lo,
  output logic [31:0]        addr_hi,
  output logic [31:0]        data_q,
  output logic [NUM_VEC-1:0] mask_q,
  output logic [NUM_VEC-1:0] mask_nxt
);
  localparam int CAP_EXP  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 0;
  localparam int DATA_OFS = data_ofs(ADDR64);
  localparam int MASK_OFS = DATA_OFS + 4;
  localparam int PEND_OFS = DATA_OFS + 8;

  logic [7:0]  ctl_lo_rd;
  logic [7:0]  ctl_lo_wr;
  logic [31:0] mask_w;
  logic [31:0] word;
  logic [5:0]  widx;

  assign ctl_lo_rd = {ADDR64, ctl.exp_en, 3'(CAP_EXP), ctl.en};
  assign ctl_lo_wr = (cfg_wdata & ~CTL_RO_BITS) | (ctl_lo_rd & CTL_RO_BITS);

  // byte-merge of the mask register, seen by the scheduler on the write edge
  always_comb begin
    mask_w = 32'(mask_q);
    for (int b = 0; b < 4; b++)
      if (cfg_we && cfg_addr == 8'(MASK_OFS + b)) mask_w[8*b +: 8] = cfg_wdata;
    mask_nxt = mask_w[NUM_VEC-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl     <= '0;
      addr_lo <= '0;
      data_q  <= '0;
      mask_q  <= '0;
    end else begin
      mask_q <= mask_nxt;
      if (cfg_we) begin
        if (cfg_addr == 8'(OFS_CTL)) begin
          ctl.en     <= ctl_lo_wr[0];
          ctl.exp_en <= ctl_lo_wr[6:4];
        end
        for (int b = 0; b < 4; b++) begin
          if (cfg_addr == 8'(OFS_ADDR_LO + b)) addr_lo[8*b +: 8] <= cfg_wdata;
          if (cfg_addr == 8'(DATA_OFS + b))    data_q[8*b +: 8]  <= cfg_wdata;
        end
      end
    end
  end

  generate
    if (ADDR64) begin : g_hi
      always_ff @(posedge clk) begin
        if (!rst_n) addr_hi <= '0;
        else if (cfg_we)
          for (int b = 0; b < 4; b++)
            if (cfg_addr == 8'(OFS_ADDR_HI + b)) addr_hi[8*b +: 8] <= cfg_wdata;
      end
    end else begin : g_no_hi
      assign addr_hi = '0;
    end
  endgenerate

  assign widx = cfg_addr[7:2];
  always_comb begin
    word = '0;
    if (widx == 6'd0)                          word = {8'h01, ctl_lo_rd, NEXT_PTR, CAP_ID_MSG_IRQ};
    else if (widx == 6'(OFS_ADDR_LO / 4))      word = addr_lo;
    else if (ADDR64 && widx == 6'(OFS_ADDR_HI / 4)) word = addr_hi;
    else if (widx == 6'(DATA_OFS / 4))         word = data_q;
    else if (widx == 6'(MASK_OFS / 4))         word = 32'(mask_q);
    else if (widx == 6'(PEND_OFS / 4))         word = 32'(pend);
  end
  assign cfg_rdata = word[{cfg_addr[1:0], 3'b000} +: 8];
endmodule

// File: rtl/msi_cap_sched.sv
module msi_cap_sched
  import msi_cap_pkg::*;
#(
  parameter int NUM_VEC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] irq_lvl,
  input  irq_ctl_t           ctl,
  input  logic [NUM_VEC-1:0] mask_q,
  input  logic [NUM_VEC-1:0] mask_nxt,
  input  logic [31:0]        addr_lo,
  input  logic [31:0]        addr_hi,
  input  logic [31:0]        data_q,
  output logic [NUM_VEC-1:0] pend,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);
  localparam int SEL_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic [NUM_VEC-1:0] irq_q, rise, live, fresh, to_pend, released, due, cand;
  logic [SEL_W-1:0]   sel;
  logic               hit, slot_free;
  logic [31:0]        vmask;

  assign vmask = (32'd1 << ctl.exp_en) - 32'd1;

  always_comb
    for (int v = 0; v < NUM_VEC; v++)
      live[v] = ctl.en && (32'(v) < (32'd1 << ctl.exp_en));

  assign rise      = irq_lvl & ~irq_q;
  assign fresh     = rise & live & ~mask_q;
  assign to_pend   = rise & live & mask_q;
  assign released  = pend & live & ~mask_nxt;
  assign cand      = (due | fresh | released) & live;
  assign slot_free = !msg_valid || msg_ready;

  // lowest-numbered queued vector wins
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int v = NUM_VEC - 1; v >= 0; v--)
      if (cand[v]) begin
        hit = 1'b1;
        sel = SEL_W'(v);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q     <= '0;
      pend      <= '0;
      due       <= '0;
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else begin
      irq_q <= irq_lvl;
      pend  <= (pend | to_pend) & ~released;
      if (slot_free) begin
        msg_valid <= hit;
        due       <= hit ? (cand & ~(NUM_VEC'(1) << sel)) : cand;
        if (hit) begin
          msg_addr <= {addr_hi, addr_lo};
          msg_data <= (data_q & ~vmask) | 32'(sel);
        end
      end else begin
        due <= cand;
      end
    end
  end
endmodule

// File: rtl/msi_cap.sv
module msi_cap
  import msi_cap_pkg::*;
#(
  parameter int         NUM_VEC  = 4,
  parameter bit         ADDR64   = 1'b1,
  parameter logic [7:0] NEXT_PTR = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         cfg_addr,
  input  logic               cfg_we,
  input  logic [7:0]         cfg_wdata,
  output logic [7:0]         cfg_rdata,
  input  logic [NUM_VEC-1:0] irq_lvl,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data
);
  irq_ctl_t           ctl;
  logic               ctl_en;
  logic [31:0]        addr_lo, addr_hi, data_q;
  logic [NUM_VEC-1:0] mask_q, mask_nxt, pend;

  assign ctl_en = ctl.en;

  msi_cap_regs #(.NUM_VEC(NUM_VEC), .ADDR64(ADDR64), .NEXT_PTR(NEXT_PTR)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pend(pend), .ctl(ctl),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .data_q(data_q),
    .mask_q(mask_q), .mask_nxt(mask_nxt)
  );

  msi_cap_sched #(.NUM_VEC(NUM_VEC)) u_sched (
    .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .ctl(ctl),
    .mask_q(mask_q), .mask_nxt(mask_nxt), .addr_lo(addr_lo), .addr_hi(addr_hi),
    .data_q(data_q), .pend(pend), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );
endmodule

// File: rtl/msi_cap_chk.sv
module msi_cap_chk #(
  parameter int NUM_VEC = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic [NUM_VEC-1:0] mask_q,
  input logic [NUM_VEC-1:0] pend,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [63:0]        msg_addr,
  input logic [31:0]        msg_data
);
  p_hold_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

  p_pend_only_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~$past(mask_q)) == '0);

  p_no_start_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !msg_valid |=> !msg_valid);

  p_no_pend_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pend & ~$past(pend)) == '0);

  p_start_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> $past(en));
endmodule

bind msi_cap msi_cap_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(ctl_en), .mask_q(mask_q), .pend(pend),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/msi_cap_bench.sv
module msi_cap_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0]  a_addr = '0, a_wd = '0, a_rd;
  logic        a_we = 1'b0, a_rdy = 1'b0, a_vld;
  logic [3:0]  a_irq = '0;
  logic [63:0] a_maddr;
  logic [31:0] a_mdata;

  logic [7:0]  b_addr = '0, b_wd = '0, b_rd;
  logic        b_we = 1'b0, b_rdy = 1'b0, b_vld;
  logic [2:0]  b_irq = '0;
  logic [63:0] b_maddr;
  logic [31:0] b_mdata;

  int checks = 0;
  int fails  = 0;

  msi_cap #(.NUM_VEC(4), .ADDR64(1'b1), .NEXT_PTR(8'h40)) u_msi_cap (
    .clk(clk), .rst_n(rst_n), .cfg_addr(a_addr), .cfg_we(a_we), .cfg_wdata(a_wd),
    .cfg_rdata(a_rd), .irq_lvl(a_irq), .msg_valid(a_vld), .msg_ready(a_rdy),
    .msg_addr(a_maddr), .msg_data(a_mdata));

  msi_cap #(.NUM_VEC(3), .ADDR64(1'b0), .NEXT_PTR(8'h00)) u_msi_cap_b (
    .clk(clk), .rst_n(rst_n), .cfg_addr(b_addr), .cfg_we(b_we), .cfg_wdata(b_wd),
    .cfg_rdata(b_rd), .irq_lvl(b_irq), .msg_valid(b_vld), .msg_ready(b_rdy),
    .msg_addr(b_maddr), .msg_data(b_mdata));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input bit s, input logic [7:0] off, input logic [7:0] v);
    @(negedge clk);
    if (!s) begin a_addr = off; a_wd = v; a_we = 1'b1; end
    else    begin b_addr = off; b_wd = v; b_we = 1'b1; end
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0;
  endtask

  task automatic rd(input bit s, input logic [7:0] off, output logic [7:0] v);
    if (!s) begin a_addr = off; #1 v = a_rd; end
    else    begin b_addr = off; #1 v = b_rd; end
  endtask

  task automatic wr32(input bit s, input logic [7:0] off, input logic [31:0] v);
    for (int b = 0; b < 4; b++) wr(s, off + 8'(b), v[8*b +: 8]);
  endtask

  task automatic rd32(input bit s, input logic [7:0] off, output logic [31:0] v);
    logic [7:0] t;
    for (int b = 0; b < 4; b++) begin rd(s, off + 8'(b), t); v[8*b +: 8] = t; end
  endtask

  task automatic chk_msg(input bit s, input bit ev, input logic [63:0] ea,
                         input logic [31:0] ed, input string tag);
    logic vv; logic [63:0] aa; logic [31:0] dd;
    vv = s ? b_vld : a_vld;
    aa = s ? b_maddr : a_maddr;
    dd = s ? b_mdata : a_mdata;
    check(vv == ev, {tag, " valid"}, 64'(vv), 64'(ev));
    if (ev) begin
      check(aa == ea, {tag, " addr"}, aa, ea);
      check(dd == ed, {tag, " data"}, 64'(dd), 64'(ed));
    end
  endtask

  task automatic accept(input bit s);
    if (!s) a_rdy = 1'b1; else b_rdy = 1'b1;
    @(negedge clk);
    a_rdy = 1'b0; b_rdy = 1'b0;
  endtask

  function automatic logic [7:0] exp_reset(input bit s, input int off);
    // R1 id/next, R2 capability exponent and layout bit, R3 high control byte
    case (off)
      0: return 8'h05;
      1: return s ? 8'h00 : 8'h40;
      2: return s ? 8'h04 : 8'h84;
      3: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  localparam logic [63:0] EA = 64'h0000_0001_FEE0_1000;

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0]  r8;
    logic [31:0] r32;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // reset sweep of both layouts: R1 R2 R3 R4
    for (int s = 0; s < 2; s++)
      for (int off = 0; off < 24; off++) begin
        rd(s[0], 8'(off), r8);
        check(r8 == exp_reset(s[0], off), "R1 R2 R3 R4 reset read", 64'(r8), 64'(exp_reset(s[0], off)));
      end
    chk_msg(0, 1'b0, '0, '0, "R5 reset idle");

    // control low byte filter sweep: R2
    for (int w = 0; w < 256; w++) begin
      wr(0, 8'h02, 8'(w));
      rd(0, 8'h02, r8);
      check(r8 == ((8'(w) & 8'h71) | 8'h84), "R2 control write filter", 64'(r8), 64'((8'(w) & 8'h71) | 8'h84));
    end
    wr(0, 8'h02, 8'h00);

    wr(0, 8'h03, 8'hFF); rd(0, 8'h03, r8);
    check(r8 == 8'h01, "R3 control high ignores write", 64'(r8), 64'h01);
    wr(0, 8'h00, 8'hFF); rd(0, 8'h00, r8);
    check(r8 == 8'h05, "R1 id ignores write", 64'(r8), 64'h05);
    wr(0, 8'h01, 8'h00); rd(0, 8'h01, r8);
    check(r8 == 8'h40, "R1 next ignores write", 64'(r8), 64'h40);

    // programming and layout: R4 R6
    wr32(0, 8'h04, 32'hFEE0_1000);
    wr32(0, 8'h08, 32'h0000_0001);
    wr32(0, 8'h0C, 32'h0000_ABC7);
    rd32(0, 8'h0C, r32);
    check(r32 == 32'h0000_ABC7, "R4 data readback", 64'(r32), 64'h0000_ABC7);
    rd32(0, 8'h08, r32);
    check(r32 == 32'h1, "R4 addr high readback", 64'(r32), 64'h1);
    wr32(0, 8'h14, 32'hFFFF_FFFF);
    rd32(0, 8'h14, r32);
    check(r32 == 32'h0, "R6 pending ignores write", 64'(r32), 64'h0);
    wr32(0, 8'h10, 32'hFFFF_FFFF);
    rd32(0, 8'h10, r32);
    check(r32 == 32'h0000_000F, "R4 mask width", 64'(r32), 64'hF);
    wr32(0, 8'h10, 32'h0);

    wr(0, 8'h02, 8'h21);   // enable, four vectors

    // single vectors: R5 R9 R11
    for (int v = 0; v < 4; v++) begin
      a_irq[v] = 1'b1;
      tick();
      chk_msg(0, 1'b1, EA, 32'hABC4 | 32'(v), "R5 R9 vector message");
      tick();
      chk_msg(0, 1'b1, EA, 32'hABC4 | 32'(v), "R11 stalled hold");
      accept(0);
      chk_msg(0, 1'b0, '0, '0, "R5 one message per edge");
      tick();
      chk_msg(0, 1'b0, '0, '0, "R5 held level quiet");
      a_irq[v] = 1'b0;
      tick(); tick();
      chk_msg(0, 1'b0, '0, '0, "R5 falling level quiet");
    end

    // simultaneous vectors: R10 R11
    a_irq = 4'b1010;
    tick();
    chk_msg(0, 1'b1, EA, 32'hABC5, "R10 lowest first");
    a_rdy = 1'b1;
    tick();
    chk_msg(0, 1'b1, EA, 32'hABC7, "R11 back-to-back next");
    tick();
    a_rdy = 1'b0;
    chk_msg(0, 1'b0, '0, '0, "R10 queue drained");
    a_irq = '0;
    tick(); tick();

    // enabled count of two: R9
    wr(0, 8'h02, 8'h11);
    a_irq[2] = 1'b1;
    tick(); tick();
    chk_msg(0, 1'b0, '0, '0, "R9 vector above count ignored");
    a_irq[0] = 1'b1;
    tick();
    chk_msg(0, 1'b1, EA, 32'hABC6, "R9 data low bits replaced");
    accept(0);
    a_irq = '0;
    tick(); tick();
    wr(0, 8'h02, 8'h21);

    // masked then released: R6 R7
    wr32(0, 8'h10, 32'h4);
    a_irq[2] = 1'b1;
    tick(); tick();
    chk_msg(0, 1'b0, '0, '0, "R6 masked no message");
    rd32(0, 8'h14, r32);
    check(r32 == 32'h4, "R6 pending set", 64'(r32), 64'h4);
    wr32(0, 8'h10, 32'h0);
    chk_msg(0, 1'b1, EA, 32'hABC6, "R7 release on unmask");
    rd32(0, 8'h14, r32);
    check(r32 == 32'h0, "R7 pending cleared", 64'(r32), 64'h0);
    accept(0);
    a_irq = '0;
    tick(); tick();

    // disabled: R8
    wr(0, 8'h02, 8'h20);
    wr32(0, 8'h10, 32'h2);
    a_irq = 4'b0011;
    tick(); tick();
    chk_msg(0, 1'b0, '0, '0, "R8 disabled no message");
    rd32(0, 8'h14, r32);
    check(r32 == 32'h0, "R8 disabled no pending", 64'(r32), 64'h0);
    wr(0, 8'h02, 8'h21);
    tick();
    chk_msg(0, 1'b0, '0, '0, "R8 old edge not replayed");
    a_irq = '0;
    wr32(0, 8'h10, 32'h0);

    // 32-bit layout instance: R2 R4 R9
    wr32(1, 8'h04, 32'h0FEE_0000);
    wr32(1, 8'h08, 32'h0000_1230);
    wr(1, 8'h02, 8'h21);
    rd(1, 8'h02, r8);
    check(r8 == 8'h25, "R2 32-bit control", 64'(r8), 64'h25);
    wr32(1, 8'h0C, 32'hFFFF_FFFF);
    rd32(1, 8'h0C, r32);
    check(r32 == 32'h7, "R4 32-bit mask offset", 64'(r32), 64'h7);
    wr32(1, 8'h0C, 32'h0);
    b_irq[2] = 1'b1;
    tick();
    chk_msg(1, 1'b1, 64'h0000_0000_0FEE_0000, 32'h1232, "R4 R9 32-bit message");
    accept(1);
    chk_msg(1, 1'b0, '0, '0, "R5 32-bit accepted");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule